// File: doc/BRIEF.md
# OFDM Symbol Peak-to-Average Power Meter

This block measures how peaky one 64-position OFDM symbol is. The same symbol arrives twice, one stream after the other. First come the frequency-domain carrier values. Then come the time-domain samples that the inverse transform made from them. Each stream carries its own valid, position index and start-of-symbol marker. The meter keeps the largest instantaneous power I²+Q² seen in the time samples. It also keeps the total power of the data carriers. Guard and DC positions are left out of that total, and so are pilot positions, even when they carry energy.

When the last time sample (index 63) is accepted, the meter latches three results and pulses a done strobe for one cycle. The results are the peak power, the data-carrier power sum, and a flag that says whether the ratio of the two exceeds a programmable threshold. The average data-carrier power is the sum divided by 48. The comparison is done without a divider: the flag is set when peak·48·256 > threshold·sum, with the threshold in unsigned 8.8 fixed point. A downstream unit, such as a peak-reduction loop, uses the flag to decide whether a symbol needs rework.

The last frequency-domain sample must be accepted at least one cycle before time index 63 is accepted.

Top module: `ofdm_par_meter`

## Requirements
- R1: After reset, `done` is 0 and `peak_pwr`, `data_sum` and `over` are all 0.
- R2: Positions are classed by index k (0..63). k=0 and k=27..37 are guard positions. k=7, 21, 43 and 57 are pilots. The other 48 positions are data carriers. `data_sum` equals the sum of I²+Q² over the data-carrier samples accepted since the last frequency start-of-symbol, including that start sample.
- R3: Guard and pilot positions add nothing to `data_sum`, even at full-scale amplitude.
- R4: `peak_pwr` equals the maximum I²+Q² over the time samples accepted since the last time start-of-symbol, including that start sample and the index-63 sample.
- R5: `done` is high for exactly the one cycle after a time sample with index 63 is accepted. The three results change only on that edge and hold their values at all other times.
- R6: `over` is 1 exactly when peak_pwr·12288 > thr·data_sum, with `thr` read as unsigned 8.8 on the accepting edge. Equality gives 0.
- R7: A start-of-symbol on either stream discards that stream's partial accumulation, even when the previous symbol was incomplete.
- R8: Cycles where a stream's valid is low change nothing, whatever its index and data carry, and they never raise `done`.
- R9: Full-scale inputs (-2048 on I and Q) give exact results without overflow. The peak is then 8388608 and the sum is 48·8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr | input | 16 | Ratio threshold, unsigned 8.8 |
| fd_valid | input | 1 | Frequency-domain sample valid |
| fd_sos | input | 1 | First frequency-domain sample of a symbol |
| fd_idx | input | 6 | Carrier position |
| fd_i | input | 12 | Carrier real part, signed |
| fd_q | input | 12 | Carrier imaginary part, signed |
| td_valid | input | 1 | Time-domain sample valid |
| td_sos | input | 1 | First time-domain sample of a symbol |
| td_idx | input | 6 | Time sample position |
| td_i | input | 12 | Time sample real part, signed |
| td_q | input | 12 | Time sample imaginary part, signed |
| peak_pwr | output | 24 | Latched peak time-domain power |
| data_sum | output | 30 | Latched data-carrier power sum |
| over | output | 1 | Latched ratio-exceeds-threshold flag |
| done | output | 1 | One-cycle result strobe |

## Verification
Corrupted accumulator state stays invisible until the next index-63 time sample. It then shows up in that very `done` cycle as a wrong peak, a wrong sum, or a flipped flag. A misclassified carrier shifts `data_sum` by that carrier's power, so the bench puts large energy on guard and pilot slots and zero on data slots to make such a slip obvious. The bench also runs a threshold exactly at the equality point, so that an off-by-one comparison flips `over`. It inserts invalid cycles carrying index 63 and loud data, so that a leaky valid qualifier corrupts results or fires `done` within one cycle.

// File: rtl/ofdm_par_meter.sv
module ofdm_par_meter #(
  parameter int IQ_W     = 12,
  parameter int THR_W    = 16,
  parameter int THR_FRAC = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [THR_W-1:0]       thr,
  input  logic                   fd_valid,
  input  logic                   fd_sos,
  input  logic [5:0]             fd_idx,
  input  logic signed [IQ_W-1:0] fd_i,
  input  logic signed [IQ_W-1:0] fd_q,
  input  logic                   td_valid,
  input  logic                   td_sos,
  input  logic [5:0]             td_idx,
  input  logic signed [IQ_W-1:0] td_i,
  input  logic signed [IQ_W-1:0] td_q,
  output logic [2*IQ_W-1:0]      peak_pwr,
  output logic [2*IQ_W+5:0]      data_sum,
  output logic                   over,
  output logic                   done
);
  localparam int PWR_W  = 2 * IQ_W;
  localparam int SUM_W  = PWR_W + 6;
  localparam int NDATA  = 48;
  localparam int CMP_W  = THR_W + SUM_W;
  localparam logic [CMP_W-1:0] SCALE = CMP_W'(NDATA) << THR_FRAC;

  function automatic logic carries_data(input logic [5:0] k);
    case (k)
      6'd0, 6'd7, 6'd21, 6'd43, 6'd57: carries_data = 1'b0;
      default:                         carries_data = !(k >= 6'd27 && k <= 6'd37);
    endcase
  endfunction

  logic signed [PWR_W-1:0] f_ii, f_qq, t_ii, t_qq;
  logic [PWR_W-1:0] f_pwr, t_pwr, peak_base, peak_next, peak_acc;
  logic [SUM_W-1:0] sum_acc, sum_base;
  logic             last_t;

  assign f_ii  = fd_i * fd_i;
  assign f_qq  = fd_q * fd_q;
  assign t_ii  = td_i * td_i;
  assign t_qq  = td_q * td_q;
  assign f_pwr = PWR_W'(f_ii) + PWR_W'(f_qq);
  assign t_pwr = PWR_W'(t_ii) + PWR_W'(t_qq);

  assign sum_base  = fd_sos ? '0 : sum_acc;
  assign peak_base = td_sos ? '0 : peak_acc;
  assign peak_next = (t_pwr > peak_base) ? t_pwr : peak_base;
  assign last_t    = td_valid && td_idx == 6'd63;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_acc <= '0;
    end else if (fd_valid) begin
      sum_acc <= sum_base + (carries_data(fd_idx) ? SUM_W'(f_pwr) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_acc <= '0;
    end else if (td_valid) begin
      peak_acc <= peak_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_pwr <= '0;
      data_sum <= '0;
      over     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= last_t;
      if (last_t) begin
        peak_pwr <= peak_next;
        data_sum <= sum_acc;
        over     <= (CMP_W'(peak_next) * SCALE) > (CMP_W'(thr) * CMP_W'(sum_acc));
      end
    end
  end
endmodule

// File: rtl/ofdm_par_meter_chk.sv
module ofdm_par_meter_chk #(
  parameter int IQ_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   td_valid,
  input logic [5:0]             td_idx,
  input logic signed [IQ_W-1:0] td_i,
  input logic signed [IQ_W-1:0] td_q,
  input logic [2*IQ_W-1:0]      peak_pwr,
  input logic [2*IQ_W+5:0]      data_sum,
  input logic                   over,
  input logic                   done
);
  logic signed [2*IQ_W-1:0] c_ii, c_qq;
  logic [2*IQ_W-1:0] c_pwr;
  assign c_ii  = td_i * td_i;
  assign c_qq  = td_q * td_q;
  assign c_pwr = (2*IQ_W)'(c_ii) + (2*IQ_W)'(c_qq);

  a_r5_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    $past(td_valid && td_idx == 6'd63) |-> done);
  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(td_valid && td_idx == 6'd63) |-> !done);
  a_r5_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(peak_pwr) && $stable(data_sum) && $stable(over)));
  a_r4_peak_covers_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> peak_pwr >= $past(c_pwr));
  a_r6_zero_peak_not_over: assert property (@(posedge clk) disable iff (!rst_n)
    (done && peak_pwr == '0) |-> !over);
  a_r6_zero_sum_over: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_sum == '0 && peak_pwr != '0) |-> over);
endmodule

bind ofdm_par_meter ofdm_par_meter_chk #(.IQ_W(IQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .td_valid(td_valid), .td_idx(td_idx),
  .td_i(td_i), .td_q(td_q), .peak_pwr(peak_pwr), .data_sum(data_sum),
  .over(over), .done(done)
);

// File: tb/ofdm_par_meter_tb.sv
module ofdm_par_meter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [15:0] thr;
  logic fd_valid, fd_sos, td_valid, td_sos;
  logic [5:0] fd_idx, td_idx;
  logic signed [11:0] fd_i, fd_q, td_i, td_q;
  logic [23:0] peak_pwr;
  logic [29:0] data_sum;
  logic over, done;

  ofdm_par_meter u_dut (
    .clk(clk), .rst_n(rst_n), .thr(thr),
    .fd_valid(fd_valid), .fd_sos(fd_sos), .fd_idx(fd_idx), .fd_i(fd_i), .fd_q(fd_q),
    .td_valid(td_valid), .td_sos(td_sos), .td_idx(td_idx), .td_i(td_i), .td_q(td_q),
    .peak_pwr(peak_pwr), .data_sum(data_sum), .over(over), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic signed [11:0] fi[64], fq[64], ti[64], tq[64];

  function automatic bit data_slot(int k);
    int s = (k < 32) ? k : k - 64;
    int a = (s < 0) ? -s : s;
    if (a == 0 || a > 26) return 0;
    if (a == 7 || a == 21) return 0;
    return 1;
  endfunction

  function automatic longint pw(logic signed [11:0] i, logic signed [11:0] q);
    return longint'(i) * longint'(i) + longint'(q) * longint'(q);
  endfunction

  function automatic logic signed [11:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[11:0];
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fd_valid = 0; fd_sos = 0; fd_idx = 6'd63; fd_i = 12'sh7ff; fd_q = -12'sd2048;
    td_valid = 0; td_sos = 0; td_idx = 6'd63; td_i = -12'sd2048; td_q = 12'sh7ff;
  endtask

  task automatic fill(int shift);
    for (int k = 0; k < 64; k++) begin
      fi[k] = rnd() >>> shift; fq[k] = rnd() >>> shift;
      ti[k] = rnd() >>> shift; tq[k] = rnd() >>> shift;
    end
  endtask

  task automatic run_symbol(string tag, bit gaps);
    longint esum = 0, epeak = 0;
    bit eover;
    int bad_done = 0;
    for (int k = 0; k < 64; k++) begin
      if (data_slot(k)) esum += pw(fi[k], fq[k]);
      if (pw(ti[k], tq[k]) > epeak) epeak = pw(ti[k], tq[k]);
    end
    eover = (epeak * 12288) > (longint'(thr) * esum);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      fd_valid = 1; fd_sos = (k == 0); fd_idx = 6'(k); fd_i = fi[k]; fd_q = fq[k];
      if (gaps) begin
        @(negedge clk);
        idle_inputs();
      end
    end
    @(negedge clk); idle_inputs();
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (done) bad_done++;
      td_valid = 1; td_sos = (k == 0); td_idx = 6'(k); td_i = ti[k]; td_q = tq[k];
      if (gaps && k != 63) begin
        @(negedge clk);
        if (done) bad_done++;
        idle_inputs();
      end
    end
    @(negedge clk); idle_inputs();
    check({tag, " R8 no done before index 63"}, bad_done, 0);
    check({tag, " R5 done pulse"}, done, 1);
    check({tag, " R4 peak"}, peak_pwr, epeak);
    check({tag, " R2 data sum"}, data_sum, esum);
    check({tag, " R6 over flag"}, over, eover);
    @(negedge clk);
    check({tag, " R5 done single cycle"}, done, 0);
    check({tag, " R5 peak held"}, peak_pwr, epeak);
    check({tag, " R5 sum held"}, data_sum, esum);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 peak", peak_pwr, 0);
    check("R1 sum", data_sum, 0);
    check("R1 over", over, 0);
  endtask

  task automatic t_random();
    thr = 16'h0A00; fill(0); run_symbol("R2 random full", 0);
    thr = 16'h0180; fill(5); run_symbol("R4 random small", 0);
  endtask

  task automatic t_excluded();
    thr = 16'h0100;
    fill(3);
    for (int k = 0; k < 64; k++) begin
      fi[k] = data_slot(k) ? 12'sd0 : -12'sd2048;
      fq[k] = data_slot(k) ? 12'sd0 : 12'sd2047;
    end
    run_symbol("R3 guard/pilot energy", 0);
    check("R3 sum zero", data_sum, 0);
  endtask

  task automatic t_fullscale();
    for (int k = 0; k < 64; k++) begin
      fi[k] = -12'sd2048; fq[k] = -12'sd2048; ti[k] = -12'sd2048; tq[k] = -12'sd2048;
    end
    thr = 16'h0100; run_symbol("R9 full scale thr=1.0", 0);
    check("R9 peak exact", peak_pwr, 8388608);
    check("R6 equality gives 0", over, 0);
    thr = 16'h00FF; run_symbol("R9 full scale thr<1.0", 0);
    check("R6 just below gives 1", over, 1);
  endtask

  task automatic t_restart();
    for (int k = 0; k < 64; k++) begin
      fi[k] = -12'sd2048; fq[k] = 12'sd2047; ti[k] = -12'sd2048; tq[k] = -12'sd2048;
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      fd_valid = 1; fd_sos = (k == 0); fd_idx = 6'(k); fd_i = fi[k]; fd_q = fq[k];
    end
    @(negedge clk); idle_inputs();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      td_valid = 1; td_sos = (k == 0); td_idx = 6'(k); td_i = ti[k]; td_q = tq[k];
    end
    @(negedge clk); idle_inputs();
    check("R7 partial gives no done", done, 0);
    thr = 16'h0300; fill(6);
    run_symbol("R7 restart after partial", 0);
  endtask

  task automatic t_gaps();
    thr = 16'h0800; fill(1);
    run_symbol("R8 invalid gaps", 1);
  endtask

  initial begin
    idle_inputs();
    thr = 16'h0100;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_random();
    t_excluded();
    t_fullscale();
    t_restart();
    t_gaps();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule